// File: doc/BRIEF.md
# Blowfish Block Cipher Engine

An iterative 64-bit Blowfish datapath that encrypts or decrypts one block at a time. The eighteen 32-bit round subkeys and the four 256-word substitution tables are loaded beforehand through a table-write port. Key expansion is done elsewhere, and this block only consumes the expanded tables.

A block is presented with a start strobe together with a direction bit. The engine runs one Feistel round per clock and then one whitening cycle. It returns the 64-bit result with a single-cycle done pulse. In an optional encrypt-and-fold mode the ciphertext is XORed into a supplied destination word instead of replacing it. This suits counter-style keystream use.

Top module: `blowfish_engine`

## Requirements
- R1: While rst_ni is low and after its release, busy_o and done_o are 0 and result_o is all zeros until the first operation completes.
- R2: A write with tw_en_i high stores tw_data_i into substitution table tw_sel_i (codes 0 to 3) at entry tw_idx_i, or into subkey tw_idx_i when tw_sel_i is 4 and tw_idx_i is below 18. Any other select or index changes nothing.
- R3: The round function takes a 32-bit half with bytes a (bits 31:24), b, c and d (bits 7:0) and yields ((T0[a] + T1[b]) XOR T2[c]) + T3[d], with sums taken modulo 2^32.
- R4: Encryption runs 16 rounds with subkeys 0 up to 15. Each round XORs the subkey into the left half, XORs the round function of that into the right half, then swaps the halves. After the last round the swap is undone, and subkey 16 is folded into the right half and subkey 17 into the left half.
- R5: Decryption uses the same structure with subkeys 17 down to 2 in the rounds, and subkey 1 into the right half and subkey 0 into the left half for whitening. Decrypting a ciphertext returns the original plaintext.
- R6: Blocks are big-endian: block_i[63:56] is the first byte and block_i[63:32] is the left half. result_o follows the same byte order.
- R7: When xor_out_i is high at start of an encryption, result_o is the ciphertext XOR dest_i. For a decryption xor_out_i has no effect.
- R8: A start accepted at a rising edge raises busy_o at that edge. done_o is high for exactly one cycle after the 17th following edge, and busy_o falls at that same edge.
- R9: start_i while busy_o is high is ignored. It changes neither the running operation nor its result.
- R10: result_o changes only at the edge that raises done_o and holds otherwise.
- R11: Table writes presented while busy_o is high are discarded, and later operations see the old table contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tw_en_i | input | 1 | Table write strobe |
| tw_sel_i | input | 3 | Table select: 0-3 substitution tables, 4 subkeys |
| tw_idx_i | input | 8 | Entry index |
| tw_data_i | input | 32 | Entry data |
| start_i | input | 1 | Start a block operation (taken while idle) |
| decrypt_i | input | 1 | 1 decrypts, 0 encrypts |
| xor_out_i | input | 1 | Fold the ciphertext into dest_i |
| block_i | input | 64 | Input block, big-endian bytes |
| dest_i | input | 64 | Destination word for the fold mode |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 64 | Result block, held until the next completion |

## Verification
The hardest situations to reach from the ports are those where a second request lands in the middle of a running operation. One case is a start strobe in round five carrying a different block and direction. The other is a table write to subkey 0 and to table 0 entry 0 while the rounds are reading them. The bench drives both at fixed cycle offsets after a start. Its behavioural model discards them. The operation's result and a later re-encryption of the same block must then match the model built on the unmodified tables. All tables are filled from a pseudo-random sequence so that every lookup path carries distinct data. Round trips through decryption and the fold mode are exercised on top of this.

// File: rtl/blowfish_pkg.sv
package blowfish_pkg;
  localparam int unsigned BLK_W      = 64;
  localparam int unsigned HALF_W     = BLK_W / 2;
  localparam int unsigned N_ROUNDS   = 16;
  localparam int unsigned N_SUBKEYS  = N_ROUNDS + 2;
  localparam int unsigned N_TABLES   = 4;
  localparam int unsigned TBL_DEPTH  = 256;
  localparam int unsigned TBL_AW     = $clog2(TBL_DEPTH);
  localparam int unsigned PK_AW      = $clog2(N_SUBKEYS);
  localparam int unsigned RND_W      = $clog2(N_ROUNDS + 1);

  typedef enum logic [2:0] {
    TSEL_T0  = 3'd0,
    TSEL_T1  = 3'd1,
    TSEL_T2  = 3'd2,
    TSEL_T3  = 3'd3,
    TSEL_KEY = 3'd4
  } tbl_sel_e;
endpackage

// File: rtl/bf_sbox.sv
module bf_sbox #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/bf_subkeys.sv
module bf_subkeys #(
  parameter int unsigned DW = 32,
  parameter int unsigned N  = 18,
  localparam int unsigned AW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  input  logic [AW-1:0] raddr_b_i,
  output logic [DW-1:0] rdata_a_o,
  output logic [DW-1:0] rdata_b_o
);
  logic [DW-1:0] key_q [N];

  always_ff @(posedge clk_i) begin
    if (we_i) key_q[waddr_i] <= wdata_i;
  end

  assign rdata_a_o = key_q[raddr_a_i];
  assign rdata_b_o = key_q[raddr_b_i];

  // R2: out-of-range subkey writes must be filtered upstream
  a_r2_key_wr_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> (32'(waddr_i) < N));
  a_r4_key_rd_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(raddr_a_i) < N) && (32'(raddr_b_i) < N));
endmodule

// File: rtl/bf_round_fn.sv
module bf_round_fn
  import blowfish_pkg::*;
(
  input  logic                clk_i,
  input  logic [N_TABLES-1:0] we_i,
  input  logic [TBL_AW-1:0]   waddr_i,
  input  logic [HALF_W-1:0]   wdata_i,
  input  logic [HALF_W-1:0]   half_i,
  output logic [HALF_W-1:0]   f_o
);
  localparam int unsigned BYTE_W = HALF_W / N_TABLES;

  logic [HALF_W-1:0] look [N_TABLES];

  // table g is indexed by byte g counted from the most significant end
  for (genvar g = 0; g < N_TABLES; g++) begin : g_tbl
    bf_sbox #(.DW(HALF_W), .DEPTH(TBL_DEPTH)) u_tbl (
      .clk_i   (clk_i),
      .we_i    (we_i[g]),
      .waddr_i (waddr_i),
      .wdata_i (wdata_i),
      .raddr_i (half_i[HALF_W-1-BYTE_W*g -: BYTE_W]),
      .rdata_o (look[g])
    );
  end

  assign f_o = ((look[0] + look[1]) ^ look[2]) + look[3];
endmodule

// File: rtl/blowfish_engine.sv
module blowfish_engine
  import blowfish_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tw_en_i,
  input  logic [2:0]        tw_sel_i,
  input  logic [7:0]        tw_idx_i,
  input  logic [31:0]       tw_data_i,
  input  logic              start_i,
  input  logic              decrypt_i,
  input  logic              xor_out_i,
  input  logic [63:0]       block_i,
  input  logic [63:0]       dest_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [63:0]       result_o
);
  logic              busy_q, done_q, dec_q, xor_q;
  logic [RND_W-1:0]  rnd_q;
  logic [HALF_W-1:0] l_q, r_q;
  logic [BLK_W-1:0]  dest_q, res_q;

  logic                wr_ok, key_we, last_rnd;
  logic [N_TABLES-1:0] tbl_we;
  logic [PK_AW-1:0]    idx_a, idx_b;
  logic [HALF_W-1:0]   key_a, key_b, lx, f_val;
  logic [BLK_W-1:0]    white, fin;

  assign wr_ok  = tw_en_i & ~busy_q;
  assign key_we = wr_ok && (tw_sel_i == TSEL_KEY) && (32'(tw_idx_i) < N_SUBKEYS);

  for (genvar g = 0; g < N_TABLES; g++) begin : g_we
    assign tbl_we[g] = wr_ok && (tw_sel_i == 3'(g));
  end

  assign last_rnd = (rnd_q == RND_W'(N_ROUNDS));
  // decrypt walks the subkeys downward; the same formula also yields the
  // right-half whitening key (16 or 1) when rnd_q reaches N_ROUNDS
  assign idx_a = dec_q ? PK_AW'(N_SUBKEYS - 1) - PK_AW'(rnd_q) : PK_AW'(rnd_q);
  assign idx_b = dec_q ? '0 : PK_AW'(N_SUBKEYS - 1);

  bf_subkeys #(.DW(HALF_W), .N(N_SUBKEYS)) u_keys (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (key_we),
    .waddr_i   (tw_idx_i[PK_AW-1:0]),
    .wdata_i   (tw_data_i),
    .raddr_a_i (idx_a),
    .raddr_b_i (idx_b),
    .rdata_a_o (key_a),
    .rdata_b_o (key_b)
  );

  assign lx = l_q ^ key_a;

  bf_round_fn u_f (
    .clk_i   (clk_i),
    .we_i    (tbl_we),
    .waddr_i (tw_idx_i),
    .wdata_i (tw_data_i),
    .half_i  (lx),
    .f_o     (f_val)
  );

  // after the final round the halves sit swapped; undo it while whitening
  assign white = {r_q ^ key_b, l_q ^ key_a};
  assign fin   = white ^ ((xor_q && !dec_q) ? dest_q : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      dec_q  <= 1'b0;
      xor_q  <= 1'b0;
      rnd_q  <= '0;
      l_q    <= '0;
      r_q    <= '0;
      dest_q <= '0;
      res_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          rnd_q  <= '0;
          dec_q  <= decrypt_i;
          xor_q  <= xor_out_i;
          dest_q <= dest_i;
          l_q    <= block_i[BLK_W-1:HALF_W];
          r_q    <= block_i[HALF_W-1:0];
        end
      end else if (last_rnd) begin
        res_q  <= fin;
        done_q <= 1'b1;
        busy_q <= 1'b0;
      end else begin
        l_q   <= r_q ^ f_val;
        r_q   <= lx;
        rnd_q <= rnd_q + 1'b1;
      end
    end
  end

  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign result_o = res_q;

  a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r8_done_ends_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));
  a_r8_round_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> (rnd_q == '0 || rnd_q == RND_W'(N_ROUNDS)));
  a_r9_mode_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !last_rnd) |=> ($stable(dec_q) && $stable(xor_q) && $stable(dest_q)));
  a_r10_result_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(result_o) |-> done_o);
  a_r11_no_write_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (tbl_we == '0 && !key_we));
endmodule

// File: tb/blowfish_engine_tb_top.sv
module blowfish_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tw_en = 1'b0;
  logic [2:0]  tw_sel = '0;
  logic [7:0]  tw_idx = '0;
  logic [31:0] tw_data = '0;
  logic        start = 1'b0, dec = 1'b0, xr = 1'b0;
  logic [63:0] blk = '0, dst = '0;
  logic        busy, done;
  logic [63:0] res;

  always #(CLK_PERIOD/2) clk = ~clk;

  blowfish_engine dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tw_en_i(tw_en), .tw_sel_i(tw_sel),
    .tw_idx_i(tw_idx), .tw_data_i(tw_data), .start_i(start),
    .decrypt_i(dec), .xor_out_i(xr), .block_i(blk), .dest_i(dst),
    .busy_o(busy), .done_o(done), .result_o(res)
  );

  int    n_vec = 0, n_bad = 0, cyc = 0;
  string cur_tag = "R1";
  logic [31:0] mp [18];
  logic [31:0] ms [4][256];
  logic [31:0] seed = 32'h1234_5678;

  logic        e_busy = 0, e_done = 0;
  logic [63:0] e_res = '0, e_pend = '0;
  int          e_cnt = 0;

  function automatic logic [31:0] next_rand();
    seed ^= seed << 13;
    seed ^= seed >> 17;
    seed ^= seed << 5;
    return seed;
  endfunction

  function automatic logic [31:0] mf(input logic [31:0] x);
    return ((ms[0][x[31:24]] + ms[1][x[23:16]]) ^ ms[2][x[15:8]]) + ms[3][x[7:0]];
  endfunction

  function automatic logic [63:0] cipher(input logic [63:0] b, input logic d);
    logic [31:0] l, r, t;
    l = b[63:32];
    r = b[31:0];
    for (int i = 0; i < 16; i++) begin
      l = l ^ mp[d ? 17 - i : i];
      r = r ^ mf(l);
      t = l; l = r; r = t;
    end
    t = l; l = r; r = t;
    r = r ^ mp[d ? 1 : 16];
    l = l ^ mp[d ? 0 : 17];
    return {l, r};
  endfunction

  // behavioural reference, stepped on the same edges as the design
  always @(posedge clk) begin
    if (!rst_n) begin
      e_busy = 0; e_done = 0; e_res = '0; e_cnt = 0;
    end else begin
      if (tw_en && !e_busy) begin
        if (tw_sel < 3'd4) ms[tw_sel[1:0]][tw_idx] = tw_data;
        else if (tw_sel == 3'd4 && tw_idx < 8'd18) mp[tw_idx[4:0]] = tw_data;
      end
      e_done = 0;
      if (e_busy) begin
        e_cnt++;
        if (e_cnt == 17) begin
          e_busy = 0; e_done = 1; e_res = e_pend;
        end
      end else if (start) begin
        e_busy = 1;
        e_cnt  = 0;
        e_pend = cipher(blk, dec) ^ ((xr && !dec) ? dst : 64'h0);
      end
    end
  end

  always @(negedge clk) begin
    n_vec++;
    if (busy !== e_busy || done !== e_done || res !== e_res) begin
      n_bad++;
      $display("FAIL %s cycle %0d: busy %b/%b done %b/%b result %h exp %h (R8 R10)",
               cur_tag, cyc, busy, e_busy, done, e_done, res, e_res);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      n_bad++;
      $display("FAIL watchdog expired at cycle %0d, got running exp finished", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic twrite(input logic [2:0] s, input logic [7:0] i, input logic [31:0] d);
    @(negedge clk);
    tw_en = 1'b1; tw_sel = s; tw_idx = i; tw_data = d;
  endtask

  task automatic run_op(input logic [63:0] b, input logic d, input logic x, input logic [63:0] w);
    @(negedge clk);
    start = 1'b1; blk = b; dec = d; xr = x; dst = w;
    @(negedge clk);
    start = 1'b0;
    repeat (17) @(negedge clk);
  endtask

  initial begin
    logic [63:0] pt, ct, ref_ct, mask;
    repeat (3) @(negedge clk);
    chk("R1", {62'h0, busy, done}, 64'h0);
    chk("R1", res, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", res, 64'h0);

    cur_tag = "R2";
    for (int t = 0; t < 4; t++)
      for (int i = 0; i < 256; i++) twrite(3'(t), 8'(i), next_rand());
    for (int i = 0; i < 18; i++) twrite(3'd4, 8'(i), next_rand());
    twrite(3'd4, 8'd20, 32'hFFFF_FFFF);   // out of range, ignored
    twrite(3'd6, 8'd0, 32'hFFFF_FFFF);    // unused select, ignored
    @(negedge clk);
    tw_en = 1'b0;

    // R3 R4 R6: byte order, left half = first four bytes
    cur_tag = "R4";
    pt = {8'h01, 8'h23, 8'h45, 8'h67, 8'h89, 8'hAB, 8'hCD, 8'hEF};
    run_op(pt, 1'b0, 1'b0, '0);
    ct = res;
    chk("R3 R4 R6 encrypt", ct, cipher(pt, 1'b0));
    cur_tag = "R5";
    run_op(ct, 1'b1, 1'b0, '0);
    chk("R5 round trip", res, pt);

    for (int k = 0; k < 4; k++) begin
      pt = {next_rand(), next_rand()};
      cur_tag = "R4";
      run_op(pt, 1'b0, 1'b0, '0);
      ct = res;
      chk("R4 encrypt", ct, cipher(pt, 1'b0));
      cur_tag = "R5";
      run_op(ct, 1'b1, 1'b0, '0);
      chk("R5 round trip", res, pt);
    end
    cur_tag = "R4";
    run_op(64'h0, 1'b0, 1'b0, '0);
    chk("R4 zero block", res, cipher(64'h0, 1'b0));

    // R7 fold mode
    cur_tag = "R7";
    pt = {next_rand(), next_rand()};
    mask = {next_rand(), next_rand()};
    run_op(pt, 1'b0, 1'b1, mask);
    chk("R7 encrypt fold", res, cipher(pt, 1'b0) ^ mask);
    ct = cipher(pt, 1'b0);
    run_op(ct, 1'b1, 1'b1, mask);
    chk("R7 decrypt ignores fold", res, pt);

    // R10 hold across idle cycles
    cur_tag = "R10";
    ct = res;
    repeat (6) @(negedge clk);
    chk("R10 hold", res, ct);

    // R9 start while busy
    cur_tag = "R9";
    pt = {next_rand(), next_rand()};
    @(negedge clk);
    start = 1'b1; blk = pt; dec = 1'b0; xr = 1'b0;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    start = 1'b1; blk = ~pt; dec = 1'b1; xr = 1'b1; dst = '1;
    @(negedge clk);
    start = 1'b0;
    repeat (12) @(negedge clk);
    chk("R9 ignored start", res, cipher(pt, 1'b0));

    // R11 writes during busy
    cur_tag = "R11";
    pt = {next_rand(), next_rand()};
    @(negedge clk);
    start = 1'b1; blk = pt; dec = 1'b0; xr = 1'b0;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    tw_en = 1'b1; tw_sel = 3'd4; tw_idx = 8'd0; tw_data = 32'hDEAD_BEEF;
    @(negedge clk);
    tw_sel = 3'd0; tw_idx = 8'd0; tw_data = 32'h0BAD_F00D;
    @(negedge clk);
    tw_en = 1'b0;
    repeat (14) @(negedge clk);
    ref_ct = cipher(pt, 1'b0);
    chk("R11 running op", res, ref_ct);
    run_op(pt, 1'b0, 1'b0, '0);
    chk("R11 tables unchanged", res, ref_ct);

    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule